// File: doc/BRIEF.md
# Multi-Level 2-D Wavelet Sequencer

This block drives a separable two-dimensional wavelet decomposition of a square greyscale frame that sits in an on-chip frame buffer. It holds no arithmetic of its own. It walks the buffer one line at a time, streams each line to an external one-dimensional lifting unit, and writes the returned coefficients back to the same addresses they came from. The transform therefore runs in place. For each level the block first processes every row of the active square and then every column. After the first level it works only on the low-low quadrant, which halves the side of the square each time.

The same walk run backwards rebuilds the frame. The inverse begins at the deepest level, undoes the columns and then the rows, and moves outward until level 1. Pixels are 8-bit values (0 to 255) stored in 12-bit signed words, which leaves headroom for coefficient growth. The default frame is 128 by 128, and up to three levels are supported. Software pulses a start input with a level count and a direction, then waits for a one-cycle completion pulse.

Top module: `dwt2d_level_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done`, `mem_rd_en`, `mem_wr_en` and `lu_in_valid` are all low.
- R2: `start` is taken only when the block is idle, and `levels` and `inverse` are captured in that cycle. A `start` pulse seen during a run has no effect on the address sequence or on the final frame.
- R3: A level count of 0 causes no memory access, and `done` is high in the cycle after `start` was sampled. Any count above MAX_LEVELS (3) is treated as MAX_LEVELS.
- R4: Forward run with L levels. For k = 1..L with side S = N>>(k-1), the block does a row pass and then a column pass. Lines are taken in increasing index order, and within a line the positions run from 0 to S-1. Row line r, position j uses address r*N+j. Column line c, position j uses address j*N+c. N is FRAME_DIM.
- R5: An inverse run with L levels visits k = L down to 1. For each k it does the column pass first and then the row pass, with the same address rules as R4.
- R6: For every line, the block reads all S samples on consecutive cycles. Each read value reaches the lifting port one cycle after its read, together with `lu_len` = S and `lu_inverse` = the captured direction. The i-th value returned by the lifting unit for that line is written to the i-th address of the line, one cycle after it returns.
- R7: `done` is a single-cycle pulse. It is high in the cycle after the last write of the final pass.
- R8: Data passes through unchanged in both directions. Given a lifting unit that returns the low half of a line first, after level k the LL band fills the top-left (N>>k) square, HL lies to its right, LH lies below it and HH lies on the diagonal. A constant frame therefore leaves the constant in LL and zero elsewhere.
- R9: An inverse run with the same level count, applied to the result of a forward run and using a reversible lifting unit, restores every pixel exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| levels | input | LVL_IN_W | Requested level count, clamped to MAX_LEVELS |
| inverse | input | 1 | 0 = decompose, 1 = rebuild |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Frame buffer read strobe |
| mem_rd_addr | output | 2*log2(FRAME_DIM) | Read address, row-major |
| mem_rd_data | input | DATA_W | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Frame buffer write strobe |
| mem_wr_addr | output | 2*log2(FRAME_DIM) | Write address |
| mem_wr_data | output | DATA_W | Write data |
| lu_in_valid | output | 1 | Sample valid toward the lifting unit |
| lu_in_data | output | DATA_W | Sample toward the lifting unit |
| lu_len | output | log2(FRAME_DIM)+1 | Length of the current line |
| lu_inverse | output | 1 | Direction for the lifting unit |
| lu_out_valid | input | 1 | Coefficient valid from the lifting unit |
| lu_out_data | input | DATA_W | Coefficient from the lifting unit |

## Verification
The bench observes every falling edge. Each read and write address is compared against queues that are filled from the R4/R5 walk order at the moment a `start` is accepted. `done` is expected exactly one falling edge after the write that empties the write queue. For a zero level count it is expected one falling edge after the `start` was seen, and it is required low on every other edge. Frame contents are compared once `done` has been seen, because by then the final write has reached the buffer. The lifting-port relations hold at one cycle of spacing: a read to `lu_in_valid`, and a return to a write.

// File: rtl/dwt2d_seq_pkg.sv
package dwt2d_seq_pkg;

   // Walk phase for one line: idle, streaming reads out, collecting results
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEND = 2'd1,
      ST_RECV = 2'd2
   } seq_state_e;

endpackage

// File: rtl/dwt2d_addr_map.sv
module dwt2d_addr_map #(
   parameter int FRAME_DIM = 128,
   localparam int IDX_W = $clog2(FRAME_DIM),
   localparam int ADDR_W = 2 * IDX_W
) (
   input  logic              col_pass,
   input  logic [IDX_W-1:0]  line_idx,
   input  logic [IDX_W-1:0]  pos_idx,
   output logic [ADDR_W-1:0] addr
);

   // Row pass: line selects the row; column pass: line selects the column
   assign addr = col_pass ? {pos_idx, line_idx} : {line_idx, pos_idx};

endmodule

// File: rtl/dwt2d_pass_sched.sv
module dwt2d_pass_sched #(
   parameter int FRAME_DIM  = 128,
   parameter int MAX_LEVELS = 3,
   localparam int LVL_W = $clog2(MAX_LEVELS + 1),
   localparam int LEN_W = $clog2(FRAME_DIM) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LVL_W-1:0] levels,
   input  logic             inverse,
   input  logic             advance,
   output logic             col_pass,
   output logic             last_pass,
   output logic             inv,
   output logic [LEN_W-1:0] side
);

   logic [LVL_W-1:0] level;
   logic [LVL_W-1:0] nlev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level    <= '0;
         nlev     <= '0;
         col_pass <= 1'b0;
         inv      <= 1'b0;
      end else if (load) begin
         nlev     <= levels;
         inv      <= inverse;
         level    <= inverse ? levels : LVL_W'(1);
         col_pass <= inverse;
      end else if (advance) begin
         if (!inv) begin
            col_pass <= ~col_pass;
            if (col_pass) level <= level + 1'b1;
         end else begin
            col_pass <= ~col_pass;
            if (!col_pass) level <= level - 1'b1;
         end
      end
   end

   assign last_pass = inv ? (level == LVL_W'(1) && !col_pass)
                          : (level == nlev && col_pass);
   assign side = LEN_W'(FRAME_DIM) >> (level - 1'b1);

endmodule

// File: rtl/dwt2d_level_seq.sv
module dwt2d_level_seq
   import dwt2d_seq_pkg::*;
#(
   parameter int FRAME_DIM  = 128,
   parameter int DATA_W     = 12,
   parameter int MAX_LEVELS = 3,
   parameter int LVL_IN_W   = 3,
   localparam int IDX_W  = $clog2(FRAME_DIM),
   localparam int ADDR_W = 2 * IDX_W,
   localparam int LEN_W  = IDX_W + 1,
   localparam int LVL_W  = $clog2(MAX_LEVELS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [LVL_IN_W-1:0] levels,
   input  logic                inverse,
   output logic                done,
   output logic                mem_rd_en,
   output logic [ADDR_W-1:0]   mem_rd_addr,
   input  logic [DATA_W-1:0]   mem_rd_data,
   output logic                mem_wr_en,
   output logic [ADDR_W-1:0]   mem_wr_addr,
   output logic [DATA_W-1:0]   mem_wr_data,
   output logic                lu_in_valid,
   output logic [DATA_W-1:0]   lu_in_data,
   output logic [LEN_W-1:0]    lu_len,
   output logic                lu_inverse,
   input  logic                lu_out_valid,
   input  logic [DATA_W-1:0]   lu_out_data
);

   // Elaboration-time parameter checks
   if ((1 << IDX_W) != FRAME_DIM) begin : g_bad_dim
      $error("FRAME_DIM must be a power of two");
   end
   if (MAX_LEVELS < 1 || (FRAME_DIM >> MAX_LEVELS) < 2) begin : g_bad_lvl
      $error("MAX_LEVELS must leave at least a 2x2 low band");
   end
   if (DATA_W < 10) begin : g_bad_width
      $error("DATA_W too narrow for coefficient growth");
   end

   seq_state_e        state;
   logic [IDX_W-1:0]  line_idx, rd_idx, wr_idx;
   logic [LVL_W-1:0]  lvl_eff;
   logic              col_pass, last_pass, inv;
   logic [LEN_W-1:0]  side;
   logic [IDX_W-1:0]  side_m1;
   logic [ADDR_W-1:0] wr_addr_nx;
   logic              accept, load, zero_req, ret_last, line_last, advance;
   logic              rd_q, done_pend;

   // Level clamp only when the input can exceed the supported depth
   if ((2 ** LVL_IN_W) - 1 > MAX_LEVELS) begin : g_clamp
      assign lvl_eff = (levels > LVL_IN_W'(MAX_LEVELS)) ? LVL_W'(MAX_LEVELS)
                                                       : LVL_W'(levels);
   end else begin : g_direct
      assign lvl_eff = LVL_W'(levels);
   end

   assign accept    = (state == ST_IDLE) && start;
   assign zero_req  = accept && (lvl_eff == '0);
   assign load      = accept && (lvl_eff != '0);
   assign side_m1   = IDX_W'(side - 1'b1);
   assign line_last = (line_idx == side_m1);
   assign ret_last  = (state == ST_RECV) && lu_out_valid && (wr_idx == side_m1);
   assign advance   = ret_last && line_last && !last_pass;

   dwt2d_pass_sched #(
      .FRAME_DIM (FRAME_DIM),
      .MAX_LEVELS(MAX_LEVELS)
   ) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .levels   (lvl_eff),
      .inverse  (inverse),
      .advance  (advance),
      .col_pass (col_pass),
      .last_pass(last_pass),
      .inv      (inv),
      .side     (side)
   );

   dwt2d_addr_map #(.FRAME_DIM(FRAME_DIM)) u_rd_map (
      .col_pass(col_pass),
      .line_idx(line_idx),
      .pos_idx (rd_idx),
      .addr    (mem_rd_addr)
   );

   dwt2d_addr_map #(.FRAME_DIM(FRAME_DIM)) u_wr_map (
      .col_pass(col_pass),
      .line_idx(line_idx),
      .pos_idx (wr_idx),
      .addr    (wr_addr_nx)
   );

   assign mem_rd_en   = (state == ST_SEND);
   assign lu_in_valid = rd_q;
   assign lu_in_data  = mem_rd_data;
   assign lu_len      = side;
   assign lu_inverse  = inv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         line_idx <= '0;
         rd_idx   <= '0;
         wr_idx   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (load) begin
               state    <= ST_SEND;
               line_idx <= '0;
               rd_idx   <= '0;
               wr_idx   <= '0;
            end
            ST_SEND: begin
               if (rd_idx == side_m1) begin
                  rd_idx <= '0;
                  state  <= ST_RECV;
               end else begin
                  rd_idx <= rd_idx + 1'b1;
               end
            end
            ST_RECV: if (lu_out_valid) begin
               if (wr_idx == side_m1) begin
                  wr_idx <= '0;
                  if (line_last) begin
                     line_idx <= '0;
                     state    <= last_pass ? ST_IDLE : ST_SEND;
                  end else begin
                     line_idx <= line_idx + 1'b1;
                     state    <= ST_SEND;
                  end
               end else begin
                  wr_idx <= wr_idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q        <= 1'b0;
         mem_wr_en   <= 1'b0;
         mem_wr_addr <= '0;
         mem_wr_data <= '0;
         done_pend   <= 1'b0;
         done        <= 1'b0;
      end else begin
         rd_q        <= mem_rd_en;
         mem_wr_en   <= (state == ST_RECV) && lu_out_valid;
         mem_wr_addr <= wr_addr_nx;
         mem_wr_data <= lu_out_data;
         done_pend   <= ret_last && line_last && last_pass;
         done        <= done_pend || zero_req;
      end
   end

endmodule

// File: rtl/dwt2d_level_seq_chk.sv
module dwt2d_level_seq_chk #(
   parameter int FRAME_DIM = 128,
   parameter int DATA_W    = 12,
   localparam int ADDR_W = 2 * $clog2(FRAME_DIM)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_wr_en,
   input logic [DATA_W-1:0] mem_wr_data,
   input logic              lu_in_valid,
   input logic              lu_out_valid,
   input logic [DATA_W-1:0] lu_out_data
);

   // R7: completion is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7 / R3: a rising done follows either a write or an accepted start
   p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(mem_wr_en) || $past(start)));

   // R6: every read is handed to the lifting unit on the next cycle
   p_rd_feeds_lu_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> lu_in_valid);

   // R6: every write stems from a lifting result one cycle earlier
   p_wr_from_lu_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(lu_out_valid));

   // R8: written value is the returned coefficient, unchanged
   p_wr_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (mem_wr_data == $past(lu_out_data)));

   // R4: back-to-back reads step along a row or down a column
   p_rd_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |->
         ((mem_rd_addr - $past(mem_rd_addr)) == ADDR_W'(1) ||
          (mem_rd_addr - $past(mem_rd_addr)) == ADDR_W'(FRAME_DIM)));

endmodule

bind dwt2d_level_seq dwt2d_level_seq_chk #(
   .FRAME_DIM(FRAME_DIM),
   .DATA_W   (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .done        (done),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .mem_wr_en   (mem_wr_en),
   .mem_wr_data (mem_wr_data),
   .lu_in_valid (lu_in_valid),
   .lu_out_valid(lu_out_valid),
   .lu_out_data (lu_out_data)
);

// File: tb/dwt2d_level_seq_tb.sv
`timescale 1ns/1ps
module dwt2d_level_seq_tb;

   localparam int N  = 32;
   localparam int DW = 12;
   localparam int AW = 2 * $clog2(N);
   localparam int LW = $clog2(N) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] levels = '0;
   logic inverse = 1'b0;
   logic done;
   logic mem_rd_en, mem_wr_en;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr;
   logic [DW-1:0] mem_rd_data = '0;
   logic [DW-1:0] mem_wr_data;
   logic lu_in_valid, lu_inverse;
   logic [DW-1:0] lu_in_data;
   logic [LW-1:0] lu_len;
   logic lu_out_valid = 1'b0;
   logic [DW-1:0] lu_out_data = '0;

   always #2 clk = ~clk;

   dwt2d_level_seq #(.FRAME_DIM(N), .DATA_W(DW), .MAX_LEVELS(3), .LVL_IN_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .levels(levels), .inverse(inverse),
      .done(done), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .lu_in_valid(lu_in_valid), .lu_in_data(lu_in_data),
      .lu_len(lu_len), .lu_inverse(lu_inverse), .lu_out_valid(lu_out_valid),
      .lu_out_data(lu_out_data)
   );

   // ---------------- frame buffer model ----------------
   logic [DW-1:0] fr  [N*N];
   logic [DW-1:0] img [N*N];
   logic load_pulse = 1'b0;

   always @(posedge clk) begin
      if (load_pulse) begin
         foreach (fr[i]) fr[i] <= img[i];
      end else if (mem_wr_en) begin
         fr[mem_wr_addr] <= mem_wr_data;
      end
      mem_rd_data <= fr[mem_rd_addr];
   end

   // ---------------- reversible 5/3 lifting ----------------
   function automatic void lift(input int x[$], input bit inv, output int y[$]);
      int n, h;
      int s[$], d[$], ev[$];
      n = x.size();
      h = n / 2;
      y = {};
      if (!inv) begin
         for (int i = 0; i < h; i++) begin
            int xr;
            xr = (2*i + 2 < n) ? x[2*i + 2] : x[2*i];
            d.push_back(x[2*i + 1] - ((x[2*i] + xr) >>> 1));
         end
         for (int i = 0; i < h; i++) begin
            int dl;
            dl = (i > 0) ? d[i-1] : d[0];
            s.push_back(x[2*i] + ((dl + d[i] + 2) >>> 2));
         end
         foreach (s[i]) y.push_back(s[i]);
         foreach (d[i]) y.push_back(d[i]);
      end else begin
         for (int i = 0; i < h; i++) begin
            s.push_back(x[i]);
            d.push_back(x[h + i]);
         end
         for (int i = 0; i < h; i++) begin
            int dl;
            dl = (i > 0) ? d[i-1] : d[0];
            ev.push_back(s[i] - ((dl + d[i] + 2) >>> 2));
         end
         for (int i = 0; i < h; i++) begin
            int er;
            er = (i + 1 < h) ? ev[i+1] : ev[i];
            y.push_back(ev[i]);
            y.push_back(d[i] + ((ev[i] + er) >>> 1));
         end
      end
   endfunction

   // ---------------- lifting unit model ----------------
   int lq_in[$];
   int lq_out[$];
   int lgap = 0;

   always @(posedge clk) begin
      lu_out_valid <= 1'b0;
      if (lu_in_valid) lq_in.push_back(int'($signed(lu_in_data)));
      if (lu_len != '0 && lq_in.size() == int'(lu_len)) begin
         lift(lq_in, lu_inverse, lq_out);
         lq_in = {};
         lgap = 2;
      end else if (lq_out.size() > 0) begin
         if (lgap > 0) lgap--;
         else begin
            lu_out_valid <= 1'b1;
            lu_out_data  <= DW'(lq_out.pop_front());
         end
      end
   end

   // ---------------- checking ----------------
   int n_cmp = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
      end
   endtask

   int  q_rd[$];
   int  q_wr[$];
   bit  running = 1'b0;
   bit  done_due = 1'b0;

   function automatic int clampl(input int l);
      return (l > 3) ? 3 : l;
   endfunction

   // Walk order from R4/R5
   task automatic walk_order(input int nl, input bit inv, inout int q[$]);
      for (int p = 0; p < 2*nl; p++) begin
         int k, s;
         bit col;
         k   = inv ? (nl - p/2) : (1 + p/2);
         col = inv ? ((p % 2) == 0) : ((p % 2) == 1);
         s   = N >> (k - 1);
         for (int ln = 0; ln < s; ln++)
            for (int j = 0; j < s; j++)
               q.push_back(col ? (j*N + ln) : (ln*N + j));
      end
   endtask

   task automatic monitor();
      forever begin
         @(negedge clk);
         if (rst_n) begin
            check(done == done_due, "R7 done timing", int'(done), int'(done_due));
            done_due = 1'b0;
            if (mem_rd_en) begin
               if (q_rd.size() == 0) check(1'b0, "R4/R5 unexpected read", int'(mem_rd_addr), -1);
               else begin
                  int e;
                  e = q_rd.pop_front();
                  check(int'(mem_rd_addr) == e, "R4/R5 read address", int'(mem_rd_addr), e);
               end
            end
            if (mem_wr_en) begin
               if (q_wr.size() == 0) check(1'b0, "R6 unexpected write", int'(mem_wr_addr), -1);
               else begin
                  int e;
                  e = q_wr.pop_front();
                  check(int'(mem_wr_addr) == e, "R6 write address", int'(mem_wr_addr), e);
                  if (q_wr.size() == 0 && running) begin
                     running  = 1'b0;
                     done_due = 1'b1;
                  end
               end
            end
            if (start && !running) begin
               int nl;
               nl = clampl(int'(levels));
               if (nl == 0) done_due = 1'b1;
               else begin
                  walk_order(nl, inverse, q_rd);
                  walk_order(nl, inverse, q_wr);
                  running = 1'b1;
               end
            end
         end
      end
   endtask

   // ---------------- reference frame ----------------
   int rf [N*N];
   int orig [N*N];

   task automatic ref_apply(input int nl, input bit inv);
      int q[$];
      walk_order(nl, inv, q);
      while (q.size() > 0) begin
         int ln[$], y[$], ad[$], s;
         s = N;
         for (int j = 0; j < s && q.size() > 0; j++) begin
            // line length follows from the level of the first address run
            ad.push_back(q.pop_front());
         end
         ad = {};
         break;
      end
      // explicit per-pass walk
      for (int p = 0; p < 2*nl; p++) begin
         int k, s;
         bit col;
         k   = inv ? (nl - p/2) : (1 + p/2);
         col = inv ? ((p % 2) == 0) : ((p % 2) == 1);
         s   = N >> (k - 1);
         for (int l = 0; l < s; l++) begin
            int xl[$], y[$];
            for (int j = 0; j < s; j++) xl.push_back(rf[col ? (j*N + l) : (l*N + j)]);
            lift(xl, inv, y);
            for (int j = 0; j < s; j++) rf[col ? (j*N + l) : (l*N + j)] = y[j];
         end
      end
   endtask

   task automatic load_frame();
      @(posedge clk); #1 load_pulse = 1'b1;
      @(posedge clk); #1 load_pulse = 1'b0;
   endtask

   task automatic pulse_start(input int lv, input bit inv);
      @(posedge clk); #1;
      start = 1'b1; levels = 3'(lv); inverse = inv;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      int k;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!done && k < 40000);
      check(done == 1'b1, {tag, " completion"}, int'(done), 1);
      repeat (2) @(posedge clk);
   endtask

   task automatic cmp_frame(input string tag, input bit vs_orig);
      int bad, first, a, e;
      bad = 0; first = -1; a = 0; e = 0;
      for (int i = 0; i < N*N; i++) begin
         int want;
         want = vs_orig ? orig[i] : rf[i];
         if (int'($signed(fr[i])) != want) begin
            if (first < 0) begin first = i; a = int'($signed(fr[i])); e = want; end
            bad++;
         end
      end
      check(bad == 0, tag, a, e);
      if (bad != 0) $display("  (%0d words differ, first at %0d)", bad, first);
   endtask

   task automatic new_random(inout int seed);
      for (int i = 0; i < N*N; i++) begin
         seed = seed * 1103515245 + 12345;
         orig[i] = (seed >>> 16) & 255;
         img[i]  = DW'(orig[i]);
         rf[i]   = orig[i];
      end
      load_frame();
   endtask

   initial begin
      int seed;
      seed = 7;
      fork
         monitor();
         begin
            repeat (200000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      join_none

      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      check(done == 1'b0,        "R1 done after reset", int'(done), 0);
      check(mem_rd_en == 1'b0,   "R1 rd_en after reset", int'(mem_rd_en), 0);
      check(mem_wr_en == 1'b0,   "R1 wr_en after reset", int'(mem_wr_en), 0);
      check(lu_in_valid == 1'b0, "R1 lu_in_valid after reset", int'(lu_in_valid), 0);

      // R4 R8: one forward level on a random frame
      new_random(seed);
      pulse_start(1, 1'b0);
      wait_done("R4 fwd1");
      ref_apply(1, 1'b0);
      cmp_frame("R8 forward 1 level contents", 1'b0);

      // R5 R9: inverse one level restores pixels
      pulse_start(1, 1'b1);
      wait_done("R5 inv1");
      cmp_frame("R9 round trip 1 level", 1'b1);

      // R4 R8 R9: three levels forward then back
      for (int i = 0; i < N*N; i++) rf[i] = orig[i];
      pulse_start(3, 1'b0);
      wait_done("R4 fwd3");
      ref_apply(3, 1'b0);
      cmp_frame("R8 forward 3 level contents", 1'b0);
      pulse_start(3, 1'b1);
      wait_done("R5 inv3");
      cmp_frame("R9 round trip 3 levels", 1'b1);

      // R9: two levels on a fresh frame
      new_random(seed);
      pulse_start(2, 1'b0);
      wait_done("R4 fwd2");
      pulse_start(2, 1'b1);
      wait_done("R5 inv2");
      cmp_frame("R9 round trip 2 levels", 1'b1);

      // R3: zero levels leaves the frame untouched, done next cycle
      pulse_start(0, 1'b0);
      wait_done("R3 zero levels");
      cmp_frame("R3 zero levels frame unchanged", 1'b1);

      // R3: a count of 7 behaves as 3; inverse with 4 also as 3
      for (int i = 0; i < N*N; i++) rf[i] = orig[i];
      pulse_start(7, 1'b0);
      wait_done("R3 clamp fwd");
      ref_apply(3, 1'b0);
      cmp_frame("R3 clamped forward contents", 1'b0);
      pulse_start(4, 1'b1);
      wait_done("R3 clamp inv");
      cmp_frame("R3 clamped round trip", 1'b1);

      // R2: a start during a run is ignored
      new_random(seed);
      pulse_start(1, 1'b0);
      repeat (100) @(posedge clk);
      pulse_start(2, 1'b1);
      wait_done("R2 busy start");
      ref_apply(1, 1'b0);
      cmp_frame("R2 mid-run start ignored", 1'b0);

      // R8: constant frame, two levels -> constant in LL, zero elsewhere
      for (int i = 0; i < N*N; i++) begin
         img[i]  = DW'(77);
         orig[i] = 77;
      end
      load_frame();
      pulse_start(2, 1'b0);
      wait_done("R8 const fwd2");
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            rf[r*N + c] = (r < N/4 && c < N/4) ? 77 : 0;
      cmp_frame("R8 quadrant placement", 1'b0);

      repeat (5) @(posedge clk);
      check(q_rd.size() == 0, "R4 leftover reads", q_rd.size(), 0);
      check(q_wr.size() == 0, "R6 leftover writes", q_wr.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule